// File: doc/BRIEF.md
# SDRAM Burst Interrupt Scheduler

This block sits on the controller side of a four-bank SDRAM with a 16-bit data path. It takes read and write requests, each with or without auto precharge, aimed at rows that some other agent has already opened. For every accepted request it puts one command on its command outputs. It then runs the column burst beat by beat. A later request to a different bank may cut that burst short. The block raises the data-mask line early enough that the data bus never carries two drivers. It drops read beats that can no longer be returned, and it reports which read beats come back and from which bank.

The block also follows each bank through its burst, through write recovery and through precharge. It pulses a per-bank flag in the cycle an auto precharge begins. It holds a per-bank busy flag while that precharge runs. A request whose bank cannot take it yet waits on a valid/ready handshake. CAS latency (2 or 3), burst length (1, 2, 4 or 8), write recovery and precharge time are parameters.

Top module: `sdram_burst_sched`

## Requirements
- R1: A request is accepted at a rising edge where `req_valid` and `req_ready` are both high. In the next cycle `cmd_o` shows 2'b01 for a read or 2'b10 for a write, together with the request's bank, column and auto-precharge flag. In every other cycle `cmd_o` is 2'b00 (no operation).
- R2: A read command on the bus in cycle C issues one beat in each of the cycles C to C+BL-1 unless it is cut short. Each beat issued in cycle X is returned as `rd_valid_o` high with `rd_bank_o` equal to the read's bank in cycle X+CL.
- R3: A read to another bank that appears in cycle C2 while a read burst is running ends the old burst. The old burst keeps only the beats it issued before C2, and the new burst's first beat returns in C2+CL.
- R4: A write command in cycle C drives `dq_oe_o` high in cycles C to C+BL-1. If a command to another bank appears in cycle C2, the last write beat of the old burst is in cycle C2-1.
- R5: When a write command appears in cycle C2, every read beat still to be returned is dropped. `rd_valid_o` stays low from C2 until a later read returns, and `rd_valid_o` and `dq_oe_o` are never high in the same cycle.
- R6: A write cannot be accepted while read data is still in flight until `dqm_o` has been high in the cycle before the write command. If the most recent read carried auto precharge, `dqm_o` must also have been high two cycles before it. `req_ready` stays low until this is met, and `dqm_o` is low in the write command's own cycle.
- R7: A read with auto precharge whose burst stops in cycle S pulses `pre_start_o[bank]` in cycle S. S is C+BL if the burst runs to its full length, or the cycle of the interrupting command if it is cut short.
- R8: A write with auto precharge whose burst stops in cycle S (same definition as R7) pulses `pre_start_o[bank]` in cycle S+TWR.
- R9: `bank_busy_o[b]` is high for exactly TRP cycles starting at the precharge start pulse. A request to a bank that is bursting, in write recovery or busy is held off by `req_ready` low. Such a request is accepted in the first cycle the bank is free.
- R10: Directly after reset every bank is open and idle. `cmd_o` is a no-operation and all strobes, flags and busy bits are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ap | input | 1 | Auto precharge after this burst |
| req_bank | input | 2 | Target bank |
| req_col | input | 8 | Start column |
| cmd_o | output | 2 | Command: 00 none, 01 read, 10 write |
| cmd_bank_o | output | 2 | Bank of the command |
| cmd_col_o | output | 8 | Column of the command |
| cmd_ap_o | output | 1 | Auto-precharge flag of the command |
| dqm_o | output | 1 | Data mask toward the memory |
| dq_oe_o | output | 1 | Controller drives a write beat |
| rd_valid_o | output | 1 | A read beat returns this cycle |
| rd_bank_o | output | 2 | Bank of the returning beat |
| bank_busy_o | output | 4 | Per-bank precharge in progress |
| pre_start_o | output | 4 | Per-bank precharge start pulse |

## Verification
A wrong burst counter or a missed interrupt shows up on `dq_oe_o` or `rd_valid_o` within CL cycles, as a beat that is too many or too few. A bank state machine stuck in the wrong state either never pulses `pre_start_o`, or pulses it a different number of cycles after the stop cycle. It can also leave `bank_busy_o` high for the wrong length of time, or let `req_ready` rise while the bank is still recovering. A bad mask-lead count moves the accept cycle of a write that follows a read by one cycle, which the bench sees directly in the cycle the handshake completes.

// File: rtl/sbis_pkg.sv
// Shared encodings for the SDRAM burst interrupt scheduler.
package sbis_pkg;
    // Command placed on the memory command outputs.
    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10
    } cmd_e;

    // Life cycle of one bank from the scheduler's point of view.
    typedef enum logic [2:0] {
        BK_IDLE,
        BK_ACTIVE,
        BK_BURST,
        BK_RECOVER,
        BK_PRECHG
    } bank_st_e;
endpackage

// File: rtl/sbis_bank_fsm.sv
// Per-bank tracker. Follows one bank through burst, write recovery and
// auto precharge. Assumes the bank's row is open at reset and is reopened
// by an outside agent after precharge. TWR and TRP must be at least 1.
module sbis_bank_fsm
    import sbis_pkg::*;
#(
    parameter int TWR = 2,
    parameter int TRP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic start_write_i,
    input  logic start_ap_i,
    input  logic stop_i,
    output logic accept_ok_o,
    output logic busy_o,
    output logic pre_start_o
);
    localparam int MAXC = (TWR > TRP) ? TWR : TRP;
    localparam int CW   = $clog2(MAXC + 1);

    bank_st_e        st_q;
    logic [CW-1:0]   cnt_q;
    logic            ap_q;
    logic            wr_q;
    logic            pre_q;

    // Advance the bank state on burst start/stop and on the timers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BK_ACTIVE;
            cnt_q <= '0;
            ap_q  <= 1'b0;
            wr_q  <= 1'b0;
            pre_q <= 1'b0;
        end else begin
            pre_q <= 1'b0;
            case (st_q)
                BK_IDLE, BK_ACTIVE: begin
                    if (start_i) begin
                        st_q <= BK_BURST;
                        ap_q <= start_ap_i;
                        wr_q <= start_write_i;
                    end
                end
                BK_BURST: begin
                    if (stop_i) begin
                        if (!ap_q) begin
                            st_q <= BK_ACTIVE;
                        end else if (wr_q) begin
                            st_q  <= BK_RECOVER;
                            cnt_q <= CW'(TWR - 1);
                        end else begin
                            st_q  <= BK_PRECHG;
                            cnt_q <= CW'(TRP - 1);
                            pre_q <= 1'b1;
                        end
                    end
                end
                BK_RECOVER: begin
                    if (cnt_q == '0) begin
                        st_q  <= BK_PRECHG;
                        cnt_q <= CW'(TRP - 1);
                        pre_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                BK_PRECHG: begin
                    if (cnt_q == '0) st_q <= BK_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                default: st_q <= BK_IDLE;
            endcase
        end
    end

    // Bank may take a new burst only when open and not recovering.
    assign accept_ok_o = (st_q == BK_ACTIVE) || (st_q == BK_IDLE);
    assign busy_o      = (st_q == BK_PRECHG);
    assign pre_start_o = pre_q;

    // R9: a burst only starts on a bank that is free.
    a_r9_start_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> accept_ok_o);
    // R7: a stop request only reaches a bank that is bursting.
    a_r7_stop_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |-> (st_q == BK_BURST));
    // R8: the precharge start flag is a single-cycle pulse.
    a_r8_pre_single: assert property (@(posedge clk) disable iff (!rst_n)
        pre_start_o |=> !pre_start_o);
    // R9: precharge start coincides with the busy window opening.
    a_r9_pre_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pre_start_o |-> busy_o);
endmodule

// File: rtl/sbis_read_pipe.sv
// Read return pipeline. A beat issued in cycle X appears on valid_o in
// cycle X+CL with its bank. A flush drops every beat in flight and the one
// being pushed. Assumes CL >= 2.
module sbis_read_pipe #(
    parameter int CL = 3,
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [BW-1:0] bank_i,
    input  logic          flush_i,
    output logic          valid_o,
    output logic [BW-1:0] bank_o,
    output logic          live_o
);
    logic [CL-1:0] v_q;
    logic [BW-1:0] bk_q [CL];

    // Shift beat-valid flags, clearing them all on a flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) v_q <= '0;
        else                   v_q <= {v_q[CL-2:0], push_i};
    end

    // First bank stage captures the issuing bank.
    always_ff @(posedge clk) begin
        if (!rst_n) bk_q[0] <= '0;
        else        bk_q[0] <= bank_i;
    end

    for (genvar s = 1; s < CL; s++) begin : g_stage
        // Carry the bank tag one stage along.
        always_ff @(posedge clk) begin
            if (!rst_n) bk_q[s] <= '0;
            else        bk_q[s] <= bk_q[s-1];
        end
    end

    assign valid_o = v_q[CL-1];
    assign bank_o  = bk_q[CL-1];
    assign live_o  = |v_q;

    // R5: after a flush nothing comes out in the next cycle.
    a_r5_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !valid_o);
endmodule

// File: rtl/sdram_burst_sched.sv
// SDRAM burst interrupt scheduler (top). Accepts read/write requests to open
// rows, issues commands, runs bursts that a request to another bank may cut
// short, leads writes with the data mask, and tracks auto precharge per bank.
// Assumes rows are opened outside this block; BL in {1,2,4,8}, CL in {2,3}.
module sdram_burst_sched
    import sbis_pkg::*;
#(
    parameter int NB   = 4,
    parameter int CL   = 3,
    parameter int BL   = 4,
    parameter int TWR  = 2,
    parameter int TRP  = 3,
    parameter int COLW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic                    req_ap,
    input  logic [$clog2(NB)-1:0]   req_bank,
    input  logic [COLW-1:0]         req_col,
    output logic [1:0]              cmd_o,
    output logic [$clog2(NB)-1:0]   cmd_bank_o,
    output logic [COLW-1:0]         cmd_col_o,
    output logic                    cmd_ap_o,
    output logic                    dqm_o,
    output logic                    dq_oe_o,
    output logic                    rd_valid_o,
    output logic [$clog2(NB)-1:0]   rd_bank_o,
    output logic [NB-1:0]           bank_busy_o,
    output logic [NB-1:0]           pre_start_o
);
    localparam int BW  = $clog2(NB);
    localparam int BCW = (BL > 1) ? $clog2(BL) : 1;

    // Current burst
    logic           b_act_q;
    logic           b_wr_q;
    logic [BW-1:0]  b_bank_q;
    logic [BCW-1:0] b_cnt_q;

    // Command outputs
    cmd_e           cmd_q;
    logic [BW-1:0]  cmd_bank_q;
    logic [COLW-1:0] cmd_col_q;
    logic           cmd_ap_q;

    // Mask lead tracking
    logic           rd_ap_q;
    logic           dqm_q;
    logic [1:0]     dqm_run_q;

    logic [NB-1:0]  bank_ok;
    logic           tgt_ok;
    logic           pipe_live;
    logic           rd_live;
    logic [1:0]     lead;
    logic           accept;
    logic           stop_any;
    logic           dqm_next;

    // Request gating: bank free, and for writes the mask lead satisfied.
    always_comb begin
        tgt_ok    = bank_ok[req_bank];
        rd_live   = (b_act_q && !b_wr_q) || pipe_live;
        lead      = rd_ap_q ? 2'd2 : 2'd1;
        req_ready = tgt_ok && (!req_write || !rd_live || (dqm_run_q >= lead));
        accept    = req_valid && req_ready;
        stop_any  = b_act_q && ((b_cnt_q == '0) || accept);
        dqm_next  = req_valid && req_write && tgt_ok && rd_live && !accept;
    end

    // Burst engine: load on accept, count beats down, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_act_q  <= 1'b0;
            b_wr_q   <= 1'b0;
            b_bank_q <= '0;
            b_cnt_q  <= '0;
        end else if (accept) begin
            b_act_q  <= 1'b1;
            b_wr_q   <= req_write;
            b_bank_q <= req_bank;
            b_cnt_q  <= BCW'(BL - 1);
        end else if (b_act_q) begin
            if (b_cnt_q == '0) b_act_q <= 1'b0;
            else               b_cnt_q <= b_cnt_q - 1'b1;
        end
    end

    // Command register: one command in the cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q      <= CMD_NOP;
            cmd_bank_q <= '0;
            cmd_col_q  <= '0;
            cmd_ap_q   <= 1'b0;
        end else begin
            cmd_q      <= accept ? (req_write ? CMD_WRITE : CMD_READ) : CMD_NOP;
            cmd_bank_q <= accept ? req_bank : '0;
            cmd_col_q  <= accept ? req_col : '0;
            cmd_ap_q   <= accept && req_ap;
        end
    end

    // Mask lead: remember last read's precharge flag, count mask cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ap_q   <= 1'b0;
            dqm_q     <= 1'b0;
            dqm_run_q <= '0;
        end else begin
            if (accept && !req_write) rd_ap_q <= req_ap;
            dqm_q <= dqm_next;
            if (!dqm_next)              dqm_run_q <= '0;
            else if (dqm_run_q != 2'd3) dqm_run_q <= dqm_run_q + 2'd1;
        end
    end

    sbis_read_pipe #(.CL(CL), .BW(BW)) u_rpipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (b_act_q && !b_wr_q),
        .bank_i  (b_bank_q),
        .flush_i (accept && req_write),
        .valid_o (rd_valid_o),
        .bank_o  (rd_bank_o),
        .live_o  (pipe_live)
    );

    for (genvar i = 0; i < NB; i++) begin : g_bank
        sbis_bank_fsm #(.TWR(TWR), .TRP(TRP)) u_fsm (
            .clk           (clk),
            .rst_n         (rst_n),
            .start_i       (accept && (req_bank == BW'(i))),
            .start_write_i (req_write),
            .start_ap_i    (req_ap),
            .stop_i        (stop_any && (b_bank_q == BW'(i))),
            .accept_ok_o   (bank_ok[i]),
            .busy_o        (bank_busy_o[i]),
            .pre_start_o   (pre_start_o[i])
        );
    end

    assign cmd_o      = cmd_q;
    assign cmd_bank_o = cmd_bank_q;
    assign cmd_col_o  = cmd_col_q;
    assign cmd_ap_o   = cmd_ap_q;
    assign dqm_o      = dqm_q;
    assign dq_oe_o    = b_act_q && b_wr_q;

    // Checker-side history for the mask lead properties.
    logic wr_after_rd_q;
    logic lead2_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_after_rd_q <= 1'b0;
            lead2_q       <= 1'b0;
        end else begin
            wr_after_rd_q <= accept && req_write && rd_live;
            lead2_q       <= rd_ap_q;
        end
    end

    // R1: every command on the bus comes from a completed handshake.
    a_r1_cmd_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != 2'b00) |-> $past(req_valid && req_ready));
    // R5: write beats and read returns never share the bus.
    a_r5_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_oe_o && rd_valid_o));
    // R6: a write behind a live read had the mask up one cycle earlier.
    a_r6_lead_one: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o == 2'b10) && wr_after_rd_q) |-> $past(dqm_o));
    // R6: behind a read with auto precharge, the mask was up two cycles earlier.
    a_r6_lead_two: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o == 2'b10) && wr_after_rd_q && lead2_q) |-> $past(dqm_o, 2));
    // R6: the write beat itself is not masked.
    a_r6_no_mask_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 2'b10) |-> !dqm_o);
    // R9: a busy bank never sees its request accepted.
    a_r9_busy_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bank_busy_o[req_bank]) |-> !req_ready);
endmodule

// File: tb/sdram_burst_sched_bench.sv
module sdram_burst_sched_bench;
    localparam int NB = 4, CL = 3, BL = 4, TWR = 2, TRP = 3, COLW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_ap = 1'b0;
    logic [1:0] req_bank = '0;
    logic [COLW-1:0] req_col = '0;
    logic req_ready;
    logic [1:0] cmd_o, cmd_bank_o, rd_bank_o;
    logic [COLW-1:0] cmd_col_o;
    logic cmd_ap_o, dqm_o, dq_oe_o, rd_valid_o;
    logic [NB-1:0] bank_busy_o, pre_start_o;

    sdram_burst_sched #(.NB(NB), .CL(CL), .BL(BL), .TWR(TWR), .TRP(TRP), .COLW(COLW))
    u_sdram_burst_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_ap(req_ap), .req_bank(req_bank), .req_col(req_col),
        .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o), .cmd_col_o(cmd_col_o), .cmd_ap_o(cmd_ap_o),
        .dqm_o(dqm_o), .dq_oe_o(dq_oe_o), .rd_valid_o(rd_valid_o), .rd_bank_o(rd_bank_o),
        .bank_busy_o(bank_busy_o), .pre_start_o(pre_start_o)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int tests = 0, fails = 0;
    task automatic chk(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    typedef struct { int t; int b; bit w; } ev_t;
    ev_t rdq[$];
    ev_t pre_exp[$];
    ev_t pre_obs[$];

    // Reference model state
    bit  running = 0;
    bit  cur_act = 0, cur_w = 0, cur_ap = 0;
    int  cur_bank = 0, cur_c = 0, cur_end = 0;
    bit  last_rd_ap = 0;
    int  pre_t [NB];
    int  blk_from [NB];
    int  pend_cyc = -1, pend_cmd = 0, pend_bank = 0;
    bit  dqm_prev = 0;
    int  acc_cyc = 0;
    int  rd_seen [NB];
    int  oe_cnt = 0;

    initial begin
        for (int i = 0; i < NB; i++) begin
            pre_t[i] = -100; blk_from[i] = -100; rd_seen[i] = 0;
        end
    end

    function automatic void finalize(int s);
        if (cur_ap) begin
            ev_t e;
            e.t = s + (cur_w ? TWR : 0); e.b = cur_bank; e.w = cur_w;
            pre_exp.push_back(e);
            pre_t[cur_bank]    = e.t;
            blk_from[cur_bank] = s;
        end
        cur_act = 0;
    endfunction

    // Monitor: reference model and scoreboard, sampled mid-cycle.
    always @(negedge clk) begin
        if (running) begin
            int n;
            bit live;
            n = cyc;
            if (cur_act && n >= cur_end) finalize(cur_end);
            live = cur_act && !cur_w;
            foreach (rdq[k]) if (rdq[k].t >= n) live = 1;

            // R1 command
            if (pend_cyc == n) begin
                chk(int'(cmd_o) == pend_cmd, "R1", "command", int'(cmd_o), pend_cmd);
                chk(int'(cmd_bank_o) == pend_bank, "R1", "command bank", int'(cmd_bank_o), pend_bank);
            end else begin
                chk(cmd_o == 2'b00, "R1", "idle command", int'(cmd_o), 0);
            end
            // R4 write beats
            chk(dq_oe_o == (cur_act && cur_w), "R4", "dq_oe", int'(dq_oe_o), int'(cur_act && cur_w));
            if (dq_oe_o) oe_cnt++;
            // R2 read returns
            if (rdq.size() > 0 && rdq[0].t == n) begin
                chk(rd_valid_o == 1'b1, "R2", "rd_valid", int'(rd_valid_o), 1);
                chk(int'(rd_bank_o) == rdq[0].b, "R2", "rd_bank", int'(rd_bank_o), rdq[0].b);
                void'(rdq.pop_front());
            end else begin
                chk(rd_valid_o == 1'b0, "R2", "no read beat", int'(rd_valid_o), 0);
            end
            if (rd_valid_o) rd_seen[rd_bank_o]++;
            // R5 bus exclusivity
            chk(!(rd_valid_o && dq_oe_o), "R5", "bus overlap", int'(rd_valid_o && dq_oe_o), 0);
            // R9 busy window
            for (int b = 0; b < NB; b++) begin
                bit eb;
                eb = (n >= pre_t[b]) && (n < pre_t[b] + TRP);
                chk(bank_busy_o[b] == eb, "R9", "bank_busy", int'(bank_busy_o[b]), int'(eb));
                if (pre_start_o[b]) begin
                    ev_t e;
                    e.t = n; e.b = b; e.w = 0;
                    pre_obs.push_back(e);
                end
            end
            // Handshake
            if (req_valid && req_ready) begin
                int b, c2;
                bit blocked;
                b  = int'(req_bank);
                c2 = n + 1;
                blocked = (n >= blk_from[b] && n < pre_t[b] + TRP) || (cur_act && cur_bank == b);
                chk(!blocked, "R9", "accept on blocked bank", 1, 0);
                if (req_write && live) begin
                    chk(dqm_o == 1'b1, "R6", "dqm one before write", int'(dqm_o), 1);
                    if (last_rd_ap)
                        chk(dqm_prev == 1'b1, "R6", "dqm two before write", int'(dqm_prev), 1);
                end
                if (cur_act) finalize((cur_end < c2) ? cur_end : c2);
                for (int k = rdq.size() - 1; k >= 0; k--)
                    if (rdq[k].t >= (req_write ? c2 : c2 + CL)) rdq.delete(k);
                cur_act = 1; cur_w = req_write; cur_ap = req_ap; cur_bank = b;
                cur_c = c2; cur_end = c2 + BL;
                if (!req_write) begin
                    last_rd_ap = req_ap;
                    for (int i = 0; i < BL; i++) begin
                        ev_t e;
                        e.t = c2 + CL + i; e.b = b; e.w = 0;
                        rdq.push_back(e);
                    end
                end
                pend_cyc = c2; pend_cmd = req_write ? 2 : 1; pend_bank = b;
                acc_cyc = n;
            end
            dqm_prev = dqm_o;
        end
    end

    // Driver: present a request and wait for the handshake.
    task automatic send(bit w, bit ap, int b, output int acc);
        req_write = w; req_ap = ap; req_bank = 2'(b); req_col = 8'(b * 16 + 3); req_valid = 1'b1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        acc = cyc;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic idle(int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic clear_counts();
        for (int i = 0; i < NB; i++) rd_seen[i] = 0;
        oe_cnt = 0;
    endtask

    // Drain, then match precharge starts as sets (R7 reads, R8 writes).
    task automatic settle();
        idle(20);
        chk(rdq.size() == 0, "R2", "pending read beats", rdq.size(), 0);
        foreach (pre_exp[i]) begin
            int hit;
            hit = -1;
            foreach (pre_obs[j]) if (hit < 0 && pre_obs[j].t == pre_exp[i].t && pre_obs[j].b == pre_exp[i].b) hit = j;
            chk(hit >= 0, pre_exp[i].w ? "R8" : "R7", "precharge start cycle", hit, pre_exp[i].t);
            if (hit >= 0) pre_obs.delete(hit);
        end
        foreach (pre_obs[j]) chk(0, "R7", "unexpected precharge start", pre_obs[j].t, -1);
        pre_exp.delete();
        pre_obs.delete();
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 20000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int a1, a2, a3;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(cmd_o == 2'b00, "R10", "cmd after reset", int'(cmd_o), 0);
        chk(!dqm_o && !dq_oe_o && !rd_valid_o, "R10", "strobes after reset", int'({dqm_o, dq_oe_o, rd_valid_o}), 0);
        chk(bank_busy_o == '0 && pre_start_o == '0, "R10", "bank flags after reset", int'({bank_busy_o, pre_start_o}), 0);
        req_valid = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R10", "ready after reset", int'(req_ready), 1);
        req_valid = 1'b0;
        @(posedge clk); #1;
        running = 1;

        // R2 plain read
        clear_counts();
        send(0, 0, 0, a1);
        settle();
        chk(rd_seen[0] == BL, "R2", "full read beats", rd_seen[0], BL);

        // R3 read cut by read after two beats
        clear_counts();
        send(0, 0, 1, a1);
        idle(1);
        send(0, 0, 2, a2);
        settle();
        chk(rd_seen[1] == 2, "R3", "interrupted read beats", rd_seen[1], 2);
        chk(rd_seen[2] == BL, "R3", "interrupting read beats", rd_seen[2], BL);

        // R7 read with auto precharge cut after one beat
        clear_counts();
        send(0, 1, 0, a1);
        send(0, 0, 1, a2);
        settle();
        chk(rd_seen[0] == 1, "R3", "one-beat read", rd_seen[0], 1);

        // R6 write behind plain read: one-cycle lead
        clear_counts();
        send(0, 0, 2, a1);
        send(1, 0, 3, a2);
        chk(a2 - a1 == 2, "R6", "write accept after plain read", a2 - a1, 2);
        settle();
        chk(rd_seen[2] == 0, "R5", "read beats dropped by write", rd_seen[2], 0);
        chk(oe_cnt == BL, "R4", "full write beats", oe_cnt, BL);

        // R6 write behind auto-precharge read: two-cycle lead
        clear_counts();
        send(0, 1, 0, a1);
        send(1, 0, 1, a2);
        chk(a2 - a1 == 3, "R6", "write accept after precharge read", a2 - a1, 3);
        settle();

        // R4 write cut by write, then R9 stall behind write auto precharge
        clear_counts();
        send(1, 0, 0, a1);
        idle(1);
        send(1, 1, 1, a2);
        send(0, 0, 1, a3);
        chk(a3 - a2 == 1 + BL + TWR + TRP, "R9", "stall until precharge done", a3 - a2, 1 + BL + TWR + TRP);
        settle();
        chk(oe_cnt == 2 + BL, "R4", "interrupted write beats", oe_cnt, 2 + BL);

        // R8 write auto precharge cut by read immediately
        clear_counts();
        send(1, 1, 2, a1);
        send(0, 0, 3, a2);
        settle();
        chk(oe_cnt == 1, "R4", "one write beat", oe_cnt, 1);
        chk(rd_seen[3] == BL, "R2", "read after write beats", rd_seen[3], BL);

        running = 0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule